// File: doc/BRIEF.md
# Iterative Hash Compression Sequencer

This block is the control half of an iterative hash engine that pushes 512-bit message blocks through a 1024-bit state, one permutation round per clock, 42 rounds per block. It drives only control: the select between the digest-size initial value and the fed-back state, the strobes that capture the message block, enable the state register and gate the two message XORs, the current round number, and a one-cycle ready flag. The wide arithmetic sits in a separate datapath that follows these signals.

A request starts with `start` while the sequencer is idle. The setup XOR overlaps round 1 and the closing XOR overlaps round 42. For a multi-block message, `more_blocks` sampled in the closing cycle sends the sequencer straight into the next block's setup, using the fed-back state, without an idle gap. Outputs are registered, so a value decided from the inputs at a clock edge is seen for the whole cycle that follows. One single-block hash takes 43 cycles: 42 round cycles and one result cycle.

The 2-bit digest-size select is captured when a message starts and turned into a 16-bit code, which the datapath zero-extends to the 1024-bit initial state.

Top module: `hcc_ctrl`

## Requirements
- R1: A synchronous `rst` drives `sel_init`, `msg_load`, `xor_in`, `xor_out`, `state_en`, `hash_ready` and `round` to zero, and `init_code` to 16'h00E0. The sequencer is then idle.
- R2: When `start`=1 is sampled while idle and `en`=1, the next cycle is the setup cycle. In it `sel_init`=1, `msg_load`=1, `xor_in`=1, `state_en`=1, `xor_out`=0 and `round`=1.
- R3: The setup cycle is followed by exactly 40 cycles with `round` counting 2 to 41, `state_en`=1 and `msg_load`, `xor_in`, `xor_out`, `hash_ready` all 0.
- R4: The cycle after round 41 is the closing cycle, with `round`=42, `xor_out`=1, `state_en`=1 and `xor_in`=0.
- R5: If `more_blocks`=0 is sampled at the end of the closing cycle, the next cycle has `hash_ready`=1, `state_en`=0 and `round`=0. This is cycle 43 counted from the edge that sampled `start`. In the following cycle the sequencer is idle with `hash_ready`=0.
- R6: If `more_blocks`=1 is sampled at the end of the closing cycle, the next cycle is a setup cycle with `sel_init`=0 (fed-back state), `msg_load`=1, `xor_in`=1 and `round`=1. `hash_ready` does not rise in between.
- R7: `init_code` gives the digest bit length for `variant_sel` 0, 1, 2, 3 as 16'h00E0, 16'h0100, 16'h0180, 16'h0200. The select is captured only at the edge that accepts `start`, and changes to it while a message is in progress do not alter `init_code`.
- R8: `start` is ignored outside the idle state: the round sequence and all strobes continue unchanged.
- R9: While `en`=0, every output holds its value and no input is acted on. Counting resumes from the held round once `en` returns to 1.
- R10: `rst` asserted in the middle of a block returns every output to its R1 value at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global advance enable; 0 freezes the sequencer |
| start | input | 1 | Begin a new message (acted on only while idle) |
| more_blocks | input | 1 | Another block of the same message follows |
| variant_sel | input | 2 | Digest size select: 0=224, 1=256, 2=384, 3=512 |
| sel_init | output | 1 | 1 selects the initial value, 0 the fed-back state |
| msg_load | output | 1 | Capture the message block into its holding register |
| xor_in | output | 1 | Apply the message XOR before the rounds |
| xor_out | output | 1 | Apply the message XOR after the last round |
| state_en | output | 1 | Enable the state register for a round |
| round | output | 6 | Current round number, 1..42, 0 outside rounds |
| init_code | output | 16 | Digest-size code for the initial state |
| hash_ready | output | 1 | Digest valid in the state register |

## Verification
The assertions assume that `en` gates the whole engine, so a cycle with `en`=0 counts as no cycle at all. They also assume that `more_blocks` is only acted on in the closing cycle. The properties that relate a cycle to the one after it therefore take `en`=1 as part of their antecedent. The bench keeps `more_blocks` at 0 except around the closing edge of a chained block, and it pulses `start` during the rounds only to show it is ignored. It drops `en` in the idle state and in the middle of the rounds, and it asserts `rst` only at block-aligned points or in the mid-block reset scenario.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_ROUND = 3'd2,
        ST_CLOSE = 3'd3,
        ST_DONE  = 3'd4
    } hcc_state_e;

    typedef struct packed {
        hcc_state_e  state;
        logic        sel_init;
        logic        msg_load;
        logic        xor_in;
        logic        xor_out;
        logic        state_en;
        logic        ready;
        logic [1:0]  vsel;
    } hcc_regs_t;

    localparam logic [1:0] VSEL_RESET = 2'd0;

endpackage

// File: rtl/hcc_round_ctr.sv
module hcc_round_ctr #(
    parameter int ROUNDS = 42,
    localparam int CNT_W = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en) begin
            if (load)
                cnt_d = CNT_W'(1);
            else if (step)
                cnt_d = cnt_q + CNT_W'(1);
            else
                cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/hcc_variant_code.sv
module hcc_variant_code #(
    parameter int CODE_W = 16
) (
    input  logic [1:0]        vsel,
    output logic [CODE_W-1:0] code
);

    // 224 for the smallest variant, otherwise 128 * (vsel + 1)
    always_comb begin
        if (vsel == 2'd0)
            code = CODE_W'(224);
        else
            code = CODE_W'((32'(vsel) + 32'd1) * 32'd128);
    end

endmodule

// File: rtl/hcc_ctrl.sv
module hcc_ctrl
    import hcc_pkg::*;
#(
    parameter int ROUNDS = 42,
    parameter int CODE_W = 16,
    localparam int RND_W = $clog2(ROUNDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic              more_blocks,
    input  logic [1:0]        variant_sel,
    output logic              sel_init,
    output logic              msg_load,
    output logic              xor_in,
    output logic              xor_out,
    output logic              state_en,
    output logic [RND_W-1:0]  round,
    output logic [CODE_W-1:0] init_code,
    output logic              hash_ready
);

    localparam logic [RND_W-1:0] LAST_MID = RND_W'(ROUNDS - 1);

    hcc_regs_t  r_d, r_q;
    logic       ctr_load, ctr_step;
    logic [RND_W-1:0] rnd_q;

    always_comb begin
        r_d = r_q;
        if (en) begin
            unique case (r_q.state)
                ST_IDLE:  if (start) r_d.state = ST_SETUP;
                ST_SETUP: r_d.state = ST_ROUND;
                ST_ROUND: if (rnd_q == LAST_MID) r_d.state = ST_CLOSE;
                ST_CLOSE: r_d.state = more_blocks ? ST_SETUP : ST_DONE;
                ST_DONE:  r_d.state = ST_IDLE;
                default:  r_d.state = ST_IDLE;
            endcase

            if (r_q.state == ST_IDLE && start)
                r_d.vsel = variant_sel;

            // strobes describe the cycle the machine is entering
            r_d.sel_init = (r_d.state == ST_SETUP) && (r_q.state == ST_IDLE);
            r_d.msg_load = (r_d.state == ST_SETUP);
            r_d.xor_in   = (r_d.state == ST_SETUP);
            r_d.xor_out  = (r_d.state == ST_CLOSE);
            r_d.state_en = (r_d.state == ST_SETUP) || (r_d.state == ST_ROUND)
                        || (r_d.state == ST_CLOSE);
            r_d.ready    = (r_d.state == ST_DONE);
        end
    end

    always_comb begin
        ctr_load = (r_d.state == ST_SETUP);
        ctr_step = (r_d.state == ST_ROUND) || (r_d.state == ST_CLOSE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.vsel  <= VSEL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    hcc_round_ctr #(.ROUNDS(ROUNDS)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .load (ctr_load),
        .step (ctr_step),
        .cnt  (rnd_q)
    );

    hcc_variant_code #(.CODE_W(CODE_W)) u_code (
        .vsel (r_q.vsel),
        .code (init_code)
    );

    assign sel_init   = r_q.sel_init;
    assign msg_load   = r_q.msg_load;
    assign xor_in     = r_q.xor_in;
    assign xor_out    = r_q.xor_out;
    assign state_en   = r_q.state_en;
    assign hash_ready = r_q.ready;
    assign round      = rnd_q;

endmodule

// File: rtl/hcc_ctrl_chk.sv
module hcc_ctrl_chk #(
    parameter int ROUNDS = 42,
    parameter int CODE_W = 16,
    localparam int RND_W = $clog2(ROUNDS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              start,
    input logic              more_blocks,
    input logic [1:0]        variant_sel,
    input logic              sel_init,
    input logic              msg_load,
    input logic              xor_in,
    input logic              xor_out,
    input logic              state_en,
    input logic [RND_W-1:0]  round,
    input logic [CODE_W-1:0] init_code,
    input logic              hash_ready
);

    // R5: the ready flag lasts one advancing cycle
    p_ready_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (en && hash_ready) |=> !hash_ready);

    // R9: a frozen cycle changes no output
    p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(round) && $stable(state_en) && $stable(hash_ready)
                 && $stable(init_code) && $stable(xor_out)));

    // R3: rounds advance by one while the state register is enabled
    p_round_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && state_en && !xor_out) |=> (round == $past(round) + 1'b1));

    // R4: the closing cycle carries the last round number
    p_close_round_r4: assert property (@(posedge clk) disable iff (rst)
        xor_out |-> (round == RND_W'(ROUNDS) && state_en));

    // R5: closing without a follow-on block yields the result cycle
    p_close_done_r5: assert property (@(posedge clk) disable iff (rst)
        (en && xor_out && !more_blocks) |=> (hash_ready && !state_en));

    // R6: chaining re-enters setup on the fed-back state
    p_chain_r6: assert property (@(posedge clk) disable iff (rst)
        (en && xor_out && more_blocks) |=> (xor_in && !sel_init && round == 1));

    // R2: a setup cycle is always round one with the message captured
    p_setup_r2: assert property (@(posedge clk) disable iff (rst)
        xor_in |-> (msg_load && state_en && round == 1));

    // R3: at most one of the phase strobes at a time
    p_phase_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xor_in, xor_out, hash_ready}));

    // R7: the size code only moves at the start of a message
    p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (en && state_en && !xor_out) |=> $stable(init_code));

endmodule

bind hcc_ctrl hcc_ctrl_chk #(.ROUNDS(ROUNDS), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .start       (start),
    .more_blocks (more_blocks),
    .variant_sel (variant_sel),
    .sel_init    (sel_init),
    .msg_load    (msg_load),
    .xor_in      (xor_in),
    .xor_out     (xor_out),
    .state_en    (state_en),
    .round       (round),
    .init_code   (init_code),
    .hash_ready  (hash_ready)
);

// File: tb/hcc_ctrl_tb.sv
module hcc_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        start = 1'b0;
    logic        more_blocks = 1'b0;
    logic [1:0]  variant_sel = 2'd0;
    logic        sel_init, msg_load, xor_in, xor_out, state_en, hash_ready;
    logic [5:0]  round;
    logic [15:0] init_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hcc_ctrl u_dut (
        .clk(clk), .rst(rst), .en(en), .start(start),
        .more_blocks(more_blocks), .variant_sel(variant_sel),
        .sel_init(sel_init), .msg_load(msg_load), .xor_in(xor_in),
        .xor_out(xor_out), .state_en(state_en), .round(round),
        .init_code(init_code), .hash_ready(hash_ready)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int v);
        case (v)
            0: return 16'h00E0;
            1: return 16'h0100;
            2: return 16'h0180;
            default: return 16'h0200;
        endcase
    endfunction

    task automatic check_idle(input string req);
        check({req, " ready"}, int'(hash_ready), 0);
        check({req, " state_en"}, int'(state_en), 0);
        check({req, " round"}, int'(round), 0);
        check({req, " strobes"}, int'({sel_init, msg_load, xor_in, xor_out}), 0);
    endtask

    // Entered in a setup cycle; runs to the result cycle or the next setup.
    task automatic run_block(input bit first, input int v, input bit more,
                             input bit busy_start, input int freeze_at);
        check("R2 sel_init", int'(sel_init), int'(first));
        check("R2 msg_load", int'(msg_load), 1);
        check("R2 xor_in", int'(xor_in), 1);
        check("R2 state_en", int'(state_en), 1);
        check("R2 round", int'(round), 1);
        check("R7 code", int'(init_code), code_of(v));
        for (int r = 2; r <= 41; r++) begin
            variant_sel = 2'(r);
            start = busy_start;
            step();
            check("R3 round", int'(round), r);
            check("R3 state_en", int'(state_en), 1);
            check("R3 strobes", int'({msg_load, xor_in, xor_out, hash_ready}), 0);
            check("R7 code held", int'(init_code), code_of(v));
            if (busy_start) check("R8 start ignored round", int'(round), r);
            if (r == freeze_at) begin
                en = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    step();
                    check("R9 frozen round", int'(round), r);
                    check("R9 frozen state_en", int'(state_en), 1);
                    check("R9 frozen ready", int'(hash_ready), 0);
                end
                en = 1'b1;
            end
        end
        start = 1'b0;
        more_blocks = more;
        step();
        check("R4 round", int'(round), 42);
        check("R4 xor_out", int'(xor_out), 1);
        check("R4 state_en", int'(state_en), 1);
        check("R4 xor_in", int'(xor_in), 0);
        step();
        more_blocks = 1'b0;
        if (more) begin
            check("R6 xor_in", int'(xor_in), 1);
            check("R6 sel_init", int'(sel_init), 0);
            check("R6 msg_load", int'(msg_load), 1);
            check("R6 round", int'(round), 1);
            check("R6 no ready", int'(hash_ready), 0);
        end else begin
            check("R5 ready", int'(hash_ready), 1);
            check("R5 state_en", int'(state_en), 0);
            check("R5 round", int'(round), 0);
            step();
            check_idle("R5 back idle");
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        check_idle("R1");
        check("R1 code", int'(init_code), 16'h00E0);
        rst = 1'b0;
        step();
        check_idle("R1 after release");
    endtask

    task automatic t_single(input int v);
        variant_sel = 2'(v);
        start = 1'b1;
        step();
        start = 1'b0;
        run_block(1'b1, v, 1'b0, 1'b0, 0);
    endtask

    task automatic t_latency();
        int n = 0;
        variant_sel = 2'd1;
        start = 1'b1;
        step();
        n = 1;
        start = 1'b0;
        while (!hash_ready && n < 60) begin
            step();
            n++;
        end
        check("R5 latency", n, 43);
        step();
    endtask

    task automatic t_chain();
        variant_sel = 2'd2;
        start = 1'b1;
        step();
        start = 1'b0;
        run_block(1'b1, 2, 1'b1, 1'b0, 0);
        run_block(1'b0, 2, 1'b1, 1'b0, 0);
        run_block(1'b0, 2, 1'b0, 1'b0, 0);
    endtask

    task automatic t_busy_start();
        variant_sel = 2'd3;
        start = 1'b1;
        step();
        start = 1'b0;
        run_block(1'b1, 3, 1'b0, 1'b1, 0);
    endtask

    task automatic t_freeze();
        en = 1'b0;
        start = 1'b1;
        step(); step();
        check_idle("R9 idle start frozen");
        en = 1'b1;
        variant_sel = 2'd0;
        step();
        start = 1'b0;
        run_block(1'b1, 0, 1'b0, 1'b0, 17);
    endtask

    task automatic t_mid_reset();
        variant_sel = 2'd3;
        start = 1'b1;
        step();
        start = 1'b0;
        for (int k = 0; k < 10; k++) step();
        check("R10 running", int'(round), 11);
        rst = 1'b1;
        step();
        check_idle("R10");
        check("R10 code", int'(init_code), 16'h00E0);
        rst = 1'b0;
        step();
        check_idle("R10 released");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        for (int v = 0; v < 4; v++) t_single(v);
        t_latency();
        t_chain();
        t_busy_start();
        t_freeze();
        t_mid_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule